// File: doc/BRIEF.md
# Timer Tick-Rate Generator

This block turns one base clock into five single-cycle tick enables, one per channel of a timer bank. Two 8-bit prescale counters cut the base rate by a programmable integer. Each prescaler drives its own power-of-two divider chain, and that chain offers taps at 1, 2, 4, 8 and 16 prescaled periods. Channels 0 and 1 share the first prescaler. Channels 2 to 4 share the second.

Each channel has a 4-bit rate code. The code picks one divider tap, or it picks an external clock pin that is synchronised into the base domain. A channel counter downstream simply advances on every cycle in which its tick is high. Software writes two configuration words through a plain write port and can read them back at any time.

Codes for the external clock are named by a parameter mask. A second parameter offsets the tap exponent, so one build can run with a minimum division of 1 and another with a minimum of 2.

Top module: `tickgen`

## Requirements
- R1: While reset is asserted every tick output is 0 and both configuration words read back as 0. After reset, every channel ticks once every 2^DIV_BASE base cycles (2 with the defaults).
- R2: A write with `wr_addr`=0 stores `wr_data[15:0]`: bits [7:0] hold prescaler 0 and bits [15:8] hold prescaler 1. A write with `wr_addr`=1 stores `wr_data[19:0]`, where channel n's rate code sits at bits [4n+3:4n]. Reading returns the stored word zero-extended to 32 bits.
- R3: A prescaler value p divides the base clock by p+1. Channels 0 and 1 follow prescaler 0; channels 2, 3 and 4 follow prescaler 1.
- R4: A rate code c that is not an external-clock code, with c+DIV_BASE ≤ 4, gives one tick every (p+1)·2^(c+DIV_BASE) base cycles. With the defaults, codes 0 to 3 give 2, 4, 8 and 16 prescaled periods.
- R5: A code whose bit is set in EXT_MASK (code 4 with the defaults) routes an external clock to the channel. Channels 0 and 1 use `ext_clk[0]`; channels 2 to 4 use `ext_clk[1]`. Each rising edge of that pin gives exactly one tick. The tick is high in the third base-clock cycle after the edge is sampled. A held-high level or a falling edge gives no tick.
- R6: A code that is neither an external-clock code nor within reach of a tap (c+DIV_BASE > 4, for example 5 and 15 with the defaults) produces no ticks.
- R7: A new prescaler value takes effect only when that prescaler's counter next wraps. The prescaled period in progress completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 1 | Word select for writes: 0 prescalers, 1 rate codes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Word select for reads |
| rd_data | output | 32 | Combinational read-back of the selected word |
| ext_clk | input | 2 | External clock pins, asynchronous to `clk` |
| tick | output | 5 | One-cycle tick enable per channel |

## Verification
Each tick is registered. A prescaled and divided tick therefore shows up one cycle after the prescaler wraps, and an external tick three base cycles after the pin rises. The bench works mostly with intervals between ticks, not absolute times, so that the free-running divider phase does not matter. It discards the first interval after every reconfiguration. The external-clock latency is checked against exact cycle counts after a drive on a falling edge. The prescaler-change test starts its write in the cycle a tick is seen and expects the old prescaled period plus one new one before the next tick (13 cycles for 9→2 at divide-by-2). All outputs are sampled at falling edges.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;

    localparam int unsigned SEL_W  = 4;
    localparam int unsigned CODE_N = 1 << SEL_W;

    typedef enum logic [1:0] {
        SRC_DIV = 2'd0,
        SRC_EXT = 2'd1,
        SRC_OFF = 2'd2
    } src_e;

    // Decide what a rate code means for a given build
    function automatic src_e classify(input logic [SEL_W-1:0] code,
                                      input int unsigned      base,
                                      input logic [CODE_N-1:0] ext_mask,
                                      input int unsigned      taps);
        if (ext_mask[code])
            return SRC_EXT;
        if ((int'(code) + int'(base)) < int'(taps))
            return SRC_DIV;
        return SRC_OFF;
    endfunction

endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] cfg_val,
    output logic             pre_tick,
    output logic [PRE_W-1:0] limit_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] limit;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        pre_tick = (st_q.cnt == st_q.limit);
        if (pre_tick) begin
            st_d.cnt   = '0;
            st_d.limit = cfg_val;  // new value picked up only at wrap
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign limit_o = st_q.limit;

endmodule

// File: rtl/tg_divider.sv
module tg_divider #(
    parameter int unsigned TAPS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pre_tick,
    output logic [TAPS-1:0] tap
);

    localparam int unsigned DIV_W = (TAPS > 1) ? TAPS - 1 : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pre_tick)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Tap k fires on every 2^k-th prescaled tick
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign tap[k] = pre_tick;
        end else begin : g_rest
            assign tap[k] = pre_tick & (&st_q.cnt[k-1:0]);
        end
    end

endmodule

// File: rtl/tg_ext_sync.sv
module tg_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = ext_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tg_chan_sel.sv
module tg_chan_sel
    import tickgen_pkg::*;
#(
    parameter int unsigned       TAPS     = 5,
    parameter int unsigned       DIV_BASE = 1,
    parameter logic [CODE_N-1:0] EXT_MASK = 16'h0010
) (
    input  logic [SEL_W-1:0] code,
    input  logic [TAPS-1:0]  tap,
    input  logic             ext_rise,
    output logic             tick_d
);

    src_e        kind;
    int unsigned expo;

    always_comb begin
        kind   = classify(code, DIV_BASE, EXT_MASK, TAPS);
        expo   = int'(code) + DIV_BASE;
        tick_d = 1'b0;
        unique case (kind)
            SRC_EXT: tick_d = ext_rise;
            SRC_DIV: begin
                for (int k = 0; k < TAPS; k++)
                    if (expo == k) tick_d = tap[k];
            end
            default: tick_d = 1'b0;
        endcase
    end

endmodule

// File: rtl/tickgen.sv
module tickgen
    import tickgen_pkg::*;
#(
    parameter int unsigned       NUM_CH   = 5,
    parameter int unsigned       PRE_W    = 8,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       MAX_LOG2 = 4,
    parameter int unsigned       DIV_BASE = 1,
    parameter logic [CODE_N-1:0] EXT_MASK = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        ext_clk,
    output logic [NUM_CH-1:0] tick
);

    localparam int unsigned TAPS   = MAX_LOG2 + 1;
    localparam int unsigned GRPS   = 2;
    localparam int unsigned PRE_TW = GRPS * PRE_W;
    localparam int unsigned SEL_TW = NUM_CH * SEL_W;

    typedef struct packed {
        logic [PRE_TW-1:0] pre;
        logic [SEL_TW-1:0] sel;
        logic [NUM_CH-1:0] tick;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [GRPS-1:0]       pre_tick;
    logic [PRE_TW-1:0]     pre_limit;
    logic [GRPS-1:0]       ext_rise;
    logic [TAPS-1:0]       taps [GRPS];
    logic [NUM_CH-1:0]     tick_next;
    logic [PRE_TW-1:0]     cfg_pre_w;
    logic [SEL_TW-1:0]     cfg_sel_w;

    assign cfg_pre_w = st_q.pre;
    assign cfg_sel_w = st_q.sel;

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        tg_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_val  (st_q.pre[g*PRE_W +: PRE_W]),
            .pre_tick (pre_tick[g]),
            .limit_o  (pre_limit[g*PRE_W +: PRE_W])
        );

        tg_divider #(.TAPS(TAPS)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_tick (pre_tick[g]),
            .tap      (taps[g])
        );

        tg_ext_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ext_in (ext_clk[g]),
            .rise   (ext_rise[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned GRP = (c < 2) ? 0 : 1;
        tg_chan_sel #(
            .TAPS     (TAPS),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) u_sel (
            .code     (st_q.sel[c*SEL_W +: SEL_W]),
            .tap      (taps[GRP]),
            .ext_rise (ext_rise[GRP]),
            .tick_d   (tick_next[c])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = tick_next;
        if (wr_en) begin
            if (wr_addr) st_d.sel = wr_data[SEL_TW-1:0];
            else         st_d.pre = wr_data[PRE_TW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr) rd_data[SEL_TW-1:0] = st_q.sel;
        else         rd_data[PRE_TW-1:0] = st_q.pre;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/tickgen_checker.sv
module tickgen_checker
    import tickgen_pkg::*;
#(
    parameter int unsigned       NUM_CH   = 5,
    parameter int unsigned       PRE_W    = 8,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       TAPS     = 5,
    parameter int unsigned       DIV_BASE = 1,
    parameter logic [CODE_N-1:0] EXT_MASK = 16'h0010
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      wr_addr,
    input logic [DATA_W-1:0]         wr_data,
    input logic [NUM_CH-1:0]         tick,
    input logic [1:0]                pre_tick,
    input logic [2*PRE_W-1:0]        pre_limit,
    input logic [1:0]                ext_rise,
    input logic [2*PRE_W-1:0]        cfg_pre,
    input logic [NUM_CH*SEL_W-1:0]   cfg_sel
);

    src_e kind [NUM_CH];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            kind[c] = classify(cfg_sel[c*SEL_W +: SEL_W], DIV_BASE, EXT_MASK, TAPS);
    end

    AST_PRE_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (cfg_pre == $past(wr_data[2*PRE_W-1:0]))); // R2

    for (genvar g = 0; g < 2; g++) begin : g_grp_chk
        AST_LIMIT_WAITS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_tick[g] |=> $stable(pre_limit[g*PRE_W +: PRE_W])); // R7
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        localparam int unsigned GRP = (c < 2) ? 0 : 1;

        AST_DIV_NEEDS_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && $past(kind[c] == SRC_DIV)) |-> $past(pre_tick[GRP])); // R3

        AST_EXT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && $past(kind[c] == SRC_EXT)) |-> $past(ext_rise[GRP])); // R5

        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(kind[c] == SRC_OFF) |-> !tick[c]); // R6
    end

endmodule

bind tickgen tickgen_checker #(
    .NUM_CH   (NUM_CH),
    .PRE_W    (PRE_W),
    .DATA_W   (DATA_W),
    .TAPS     (TAPS),
    .DIV_BASE (DIV_BASE),
    .EXT_MASK (EXT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick      (tick),
    .pre_tick  (pre_tick),
    .pre_limit (pre_limit),
    .ext_rise  (ext_rise),
    .cfg_pre   (cfg_pre_w),
    .cfg_sel   (cfg_sel_w)
);

// File: tb/tickgen_bench.sv
module tickgen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 5;
    localparam int TMO        = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              rd_addr = 1'b0;
    logic [31:0]       rd_data;
    logic [1:0]        ext_clk = '0;
    logic [NUM_CH-1:0] tick;

    int n_chk  = 0;
    int n_fail = 0;
    int cnt_a, cnt_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    tickgen u_tickgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] data);
        @(negedge clk);
        rd_addr = addr;
        #1 data = rd_data;
    endtask

    // Wait (at falling edges) until channel ch ticks
    task automatic wait_tick(input int ch, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if (tick[ch]) begin ok = 1'b1; break; end
        end
    endtask

    // Settle, then return the cycle count between two ticks
    task automatic interval(input int ch, output int iv);
        bit ok;
        iv = -1;
        wait_tick(ch, ok);
        wait_tick(ch, ok);
        if (!ok) return;
        for (int i = 1; i <= TMO; i++) begin
            @(negedge clk);
            if (tick[ch]) begin iv = i; return; end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_a += int'(tick[0]);
            cnt_b += int'(tick[3]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tick == '0, "R1", "ticks in reset", tick, 0);
        rd(1'b0, v); check(v == 0, "R1", "word0 in reset", v, 0);
        rd(1'b1, v); check(v == 0, "R1", "word1 in reset", v, 0);
        rst_n = 1'b1;
        begin
            int iv;
            interval(0, iv); check(iv == 2, "R1", "default ch0 interval", iv, 2);
            interval(4, iv); check(iv == 2, "R1", "default ch4 interval", iv, 2);
        end
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(1'b0, 32'hFFFF_ABCD);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b0, v); check(v == 32'h0000_ABCD, "R2", "word0 readback", v, 32'h0000_ABCD);
        rd(1'b1, v); check(v == 32'h000F_FFFF, "R2", "word1 readback", v, 32'h000F_FFFF);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_prescale();
        int iv;
        wr(1'b1, 32'h0);                 // all codes 0 -> divide by 2
        wr(1'b0, {16'h0, 8'd2, 8'd4});   // p1=2, p0=4
        interval(0, iv); check(iv == 10, "R3", "ch0 p0=4", iv, 10);
        interval(1, iv); check(iv == 10, "R3", "ch1 p0=4", iv, 10);
        interval(2, iv); check(iv == 6,  "R3", "ch2 p1=2", iv, 6);
        interval(4, iv); check(iv == 6,  "R3", "ch4 p1=2", iv, 6);
        // single-cycle width
        begin
            bit ok;
            wait_tick(2, ok);
            @(negedge clk);
            check(tick[2] == 1'b0, "R3", "tick width", tick[2], 0);
        end
    endtask

    task automatic t_divider();
        int iv;
        wr(1'b0, {16'h0, 8'd0, 8'd1});   // p0=1
        for (int c = 0; c < 4; c++) begin
            wr(1'b1, 32'(c));
            interval(0, iv);
            check(iv == (2 << (c + 1)), "R4", $sformatf("code %0d interval", c), iv, 2 << (c + 1));
        end
    endtask

    task automatic t_off();
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0000_0050);          // ch1 code 5, ch0 code 0
        repeat (3) @(negedge clk);
        cnt_a = 0; cnt_b = 0;
        begin
            int off_cnt = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                off_cnt += int'(tick[1]);
                cnt_a   += int'(tick[0]);
            end
            check(off_cnt == 0, "R6", "code 5 ticks", off_cnt, 0);
            check(cnt_a == 50, "R6", "ch0 still ticking", cnt_a, 50);
            wr(1'b1, 32'h0000_00F0);       // ch1 code 15
            repeat (3) @(negedge clk);
            off_cnt = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                off_cnt += int'(tick[1]);
            end
            check(off_cnt == 0, "R6", "code 15 ticks", off_cnt, 0);
        end
    endtask

    task automatic t_ext();
        wr(1'b1, 32'h0000_4004);          // ch0 and ch3 on external clock
        repeat (4) @(negedge clk);
        cnt_a = 0; cnt_b = 0;
        ext_clk[0] = 1'b1;                // driven just after a falling edge
        step(2);
        check(tick[0] == 1'b0, "R5", "ext tick before 3rd edge", tick[0], 0);
        step(1);
        check(tick[0] == 1'b1, "R5", "ext tick at 3rd edge", tick[0], 1);
        step(1);
        check(tick[0] == 1'b0, "R5", "ext tick one cycle", tick[0], 0);
        step(4); ext_clk[0] = 1'b0; step(6);
        for (int p = 0; p < 2; p++) begin
            ext_clk[0] = 1'b1; step(7);
            ext_clk[0] = 1'b0; step(5);
        end
        check(cnt_a == 3, "R5", "ext0 rise count on ch0", cnt_a, 3);
        check(cnt_b == 0, "R5", "ext0 leaks to ch3", cnt_b, 0);
        cnt_a = 0; cnt_b = 0;
        for (int p = 0; p < 2; p++) begin
            ext_clk[1] = 1'b1; step(6);
            ext_clk[1] = 1'b0; step(6);
        end
        check(cnt_b == 2, "R5", "ext1 rise count on ch3", cnt_b, 2);
        check(cnt_a == 0, "R5", "ext1 leaks to ch0", cnt_a, 0);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_wrap();
        bit ok;
        int n;
        wr(1'b1, 32'h0);
        wr(1'b0, {16'h0, 8'd0, 8'd9});    // p0=9, interval 20
        wait_tick(0, ok);
        wait_tick(0, ok);
        wait_tick(0, ok);
        // write p0=2 in the cycle right after a tick
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = {16'h0, 8'd0, 8'd2};
        n = -1;
        for (int i = 1; i <= TMO; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (tick[0]) begin n = i; break; end
        end
        check(n == 13, "R7", "interval across prescaler change", n, 13);
        n = -1;
        for (int i = 1; i <= TMO; i++) begin
            @(negedge clk);
            if (tick[0]) begin n = i; break; end
        end
        check(n == 6, "R7", "interval after change", n, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_readback();
        t_prescale();
        t_divider();
        t_off();
        t_ext();
        t_wrap();
        finish_run();
    end

endmodule